// File: doc/BRIEF.md
# Width-Matching Dual-Port Parity RAM

This block is a dual-port synchronous RAM with one shared store. The store holds 16,384 data bits and 2,048 parity bits. The data width of each port is fixed at elaboration time, and the two ports may use different widths. A port that is one, two or four bits wide has no parity. A port that is eight, sixteen or thirty-two bits wide carries one parity bit for each data byte. The address width of each port follows from its data width, so every port reaches the whole data store.

When the two widths differ, the RAM packs and unpacks words across the ports. Several words written through the narrow port come back as one word on the wide port. A word written through the wide port comes back in pieces through the narrow port. Each parity bit stays with the data byte it was written alongside, whatever width reads that byte.

Both ports share one clock. An access happens on the clock edge while the port's enable is high, and its result is registered for one cycle.

Top module: `wm_dpram`

## Requirements
- R1: The data width of a port is 1, 2, 4, 8, 16 or 32 bits. Ports of width 8, 16 and 32 carry 1, 2 and 4 parity bits. The port's address has 14 − log2(width) bits, and every address from zero up to the top address (16383 down to 511) reaches its own storage.
- R2: A read presented with enable high on one clock edge shows its data and parity at the outputs after that edge, and the outputs keep that value until the port's next enabled access.
- R3: On an enabled write, the port's data and parity outputs show the values just written (write-first).
- R4: While a port's enable is low, the port neither reads nor writes. Its outputs hold their previous value, even if its write enable is high.
- R5: Narrow word n belongs to wide word n / k, where k is the wide width divided by the narrow width. It sits in lane n mod k, and lane 0 takes the least significant bits. A read through the wide port returns the k narrow words written at n = wide address × k through wide address × k + k − 1.
- R6: A word written through a wide port reads back through a narrow port as k successive narrow words, lowest lane first.
- R7: Parity bit j of a port word goes with data bits [8j+7:8j]. When a byte is reached at another parity-carrying width, it returns the parity that was stored with it.
- R8: On a port of width 1, 2 or 4, the parity input has no effect on the stored parity and the parity output is always zero.
- R9: While reset is low, both ports' outputs are zero. Reset leaves the stored contents unchanged.
- R10: When one port reads bits that the other port writes on the same edge, the read returns the earlier contents. Two ports writing the same bits on the same edge leave those bits undefined, and such traffic is excluded.
- R11: Both ports address the same store, so data and parity written through either port can be read through the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of the output registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 14 − log2(A_DW) | Port A word address |
| a_din | input | A_DW | Port A write data |
| a_pin | input | max(A_DW/8, 1) | Port A write parity, ignored when A_DW < 8 |
| a_dout | output | A_DW | Port A read data |
| a_pout | output | max(A_DW/8, 1) | Port A read parity, zero when A_DW < 8 |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 14 − log2(B_DW) | Port B word address |
| b_din | input | B_DW | Port B write data |
| b_pin | input | max(B_DW/8, 1) | Port B write parity, ignored when B_DW < 8 |
| b_dout | output | B_DW | Port B read data |
| b_pout | output | max(B_DW/8, 1) | Port B read parity, zero when B_DW < 8 |

## Verification
The bench builds two copies of the block. One pairs an 8-bit port with a 32-bit port, which exercises byte-to-word packing with one parity bit per byte on both sides. The other pairs a 1-bit port with a 16-bit port, which exercises sixteen-way bit packing and a port whose parity input must be ignored. Both copies are filled through their wide port before any reads. A bit-level model of the data and parity store gives the expected value of every read, including reads at each port's highest address.

// File: rtl/wm_dpram_pkg.sv
package wm_dpram_pkg;

    // Storage is kept as rows of 32 data bits plus 4 parity bits
    localparam int ROW_DATA  = 32;
    localparam int ROW_PAR   = 4;
    localparam int ROW_BITS  = ROW_DATA + ROW_PAR;
    localparam int TOTAL_BITS = 16384;
    localparam int ROWS      = TOTAL_BITS / ROW_DATA;
    localparam int ROW_AW    = $clog2(ROWS);
    localparam int LOG_TOTAL = $clog2(TOTAL_BITS);

    // Address bits a port needs for a given data width
    function automatic int addr_bits(input int dw);
        return LOG_TOTAL - $clog2(dw);
    endfunction

    // Parity bits carried by a port of a given data width
    function automatic int par_bits(input int dw);
        return (dw >= 8) ? dw / 8 : 0;
    endfunction

    // Width of the parity pins (at least one)
    function automatic int par_pins(input int dw);
        return (dw >= 8) ? dw / 8 : 1;
    endfunction

endpackage

// File: rtl/wm_dpram_port.sv
module wm_dpram_port
    import wm_dpram_pkg::*;
#(
    parameter  int DW  = 8,
    localparam int AW  = addr_bits(DW),
    localparam int PPW = par_pins(DW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       din,
    input  logic [PPW-1:0]      pin,
    input  logic [ROW_BITS-1:0] row_rd,
    output logic [ROW_AW-1:0]   row_idx,
    output logic [ROW_BITS-1:0] wmask,
    output logic [ROW_BITS-1:0] wval,
    output logic [DW-1:0]       dout,
    output logic [PPW-1:0]      pout
);

    localparam int PW    = par_bits(DW);
    localparam int LANES = ROW_DATA / DW;

    typedef struct packed {
        logic [DW-1:0]  d;
        logic [PPW-1:0] p;
    } port_out_t;

    port_out_t  out_d, out_q;
    logic [4:0] lane;
    logic       wr;

    // Row holding this word, and which lane of that row it occupies
    assign row_idx = ROW_AW'(addr / LANES);
    assign lane    = 5'(addr % LANES);
    assign wr      = en & we;

    // Bit-level write mask and write value into the addressed row
    always_comb begin
        wmask = '0;
        wval  = '0;
        for (int k = 0; k < ROW_DATA; k++) begin
            wval[k] = din[k % DW];
            if (wr && ((k / DW) == int'(lane))) begin
                wmask[k] = 1'b1;
            end
        end
        for (int j = 0; j < ROW_PAR; j++) begin
            wval[ROW_DATA + j] = pin[j % PPW];
            if ((PW > 0) && wr && ((j / PPW) == int'(lane))) begin
                wmask[ROW_DATA + j] = 1'b1;
            end
        end
    end

    // Output register: write-first on own writes, hold when disabled
    always_comb begin
        out_d = out_q;
        if (en) begin
            if (we) begin
                out_d.d = din;
            end else begin
                out_d.d = row_rd[int'(lane) * DW +: DW];
            end
            if (PW > 0) begin
                if (we) begin
                    out_d.p = pin;
                end else begin
                    out_d.p = row_rd[ROW_DATA + (int'(lane) % ROW_PAR) * PPW +: PPW];
                end
            end else begin
                out_d.p = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout = out_q.d;
    assign pout = out_q.p;

endmodule

// File: rtl/wm_dpram_store.sv
module wm_dpram_store
    import wm_dpram_pkg::*;
(
    input  logic                clk,
    input  logic [ROW_AW-1:0]   a_row,
    input  logic [ROW_BITS-1:0] a_mask,
    input  logic [ROW_BITS-1:0] a_val,
    input  logic [ROW_AW-1:0]   b_row,
    input  logic [ROW_BITS-1:0] b_mask,
    input  logic [ROW_BITS-1:0] b_val,
    output logic [ROW_BITS-1:0] a_rd,
    output logic [ROW_BITS-1:0] b_rd
);

    logic [ROW_BITS-1:0] mem [ROWS];

    // Bit-masked row writes; overlapping bits from both ports are undefined by contract
    always_ff @(posedge clk) begin
        for (int k = 0; k < ROW_BITS; k++) begin
            if (a_mask[k]) begin
                mem[a_row][k] <= a_val[k];
            end
        end
        for (int k = 0; k < ROW_BITS; k++) begin
            if (b_mask[k]) begin
                mem[b_row][k] <= b_val[k];
            end
        end
    end

    assign a_rd = mem[a_row];
    assign b_rd = mem[b_row];

endmodule

// File: rtl/wm_dpram.sv
module wm_dpram
    import wm_dpram_pkg::*;
#(
    parameter  int A_DW  = 8,
    parameter  int B_DW  = 32,
    localparam int A_AW  = addr_bits(A_DW),
    localparam int B_AW  = addr_bits(B_DW),
    localparam int A_PPW = par_pins(A_DW),
    localparam int B_PPW = par_pins(B_DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic             a_we,
    input  logic [A_AW-1:0]  a_addr,
    input  logic [A_DW-1:0]  a_din,
    input  logic [A_PPW-1:0] a_pin,
    output logic [A_DW-1:0]  a_dout,
    output logic [A_PPW-1:0] a_pout,
    input  logic             b_en,
    input  logic             b_we,
    input  logic [B_AW-1:0]  b_addr,
    input  logic [B_DW-1:0]  b_din,
    input  logic [B_PPW-1:0] b_pin,
    output logic [B_DW-1:0]  b_dout,
    output logic [B_PPW-1:0] b_pout
);

    logic [ROW_AW-1:0]   a_row, b_row;
    logic [ROW_BITS-1:0] a_mask, b_mask, a_val, b_val, a_rd, b_rd;

    wm_dpram_port #(.DW(A_DW)) u_port_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (a_en),
        .we      (a_we),
        .addr    (a_addr),
        .din     (a_din),
        .pin     (a_pin),
        .row_rd  (a_rd),
        .row_idx (a_row),
        .wmask   (a_mask),
        .wval    (a_val),
        .dout    (a_dout),
        .pout    (a_pout)
    );

    wm_dpram_port #(.DW(B_DW)) u_port_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (b_en),
        .we      (b_we),
        .addr    (b_addr),
        .din     (b_din),
        .pin     (b_pin),
        .row_rd  (b_rd),
        .row_idx (b_row),
        .wmask   (b_mask),
        .wval    (b_val),
        .dout    (b_dout),
        .pout    (b_pout)
    );

    wm_dpram_store u_store (
        .clk    (clk),
        .a_row  (a_row),
        .a_mask (a_mask),
        .a_val  (a_val),
        .b_row  (b_row),
        .b_mask (b_mask),
        .b_val  (b_val),
        .a_rd   (a_rd),
        .b_rd   (b_rd)
    );

endmodule

// File: rtl/wm_dpram_chk.sv
module wm_dpram_chk
    import wm_dpram_pkg::*;
#(
    parameter  int A_DW  = 8,
    parameter  int B_DW  = 32,
    localparam int A_PPW = par_pins(A_DW),
    localparam int B_PPW = par_pins(B_DW)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_en,
    input logic             a_we,
    input logic [A_DW-1:0]  a_din,
    input logic [A_PPW-1:0] a_pin,
    input logic [A_DW-1:0]  a_dout,
    input logic [A_PPW-1:0] a_pout,
    input logic             b_en,
    input logic             b_we,
    input logic [B_DW-1:0]  b_din,
    input logic [B_PPW-1:0] b_pin,
    input logic [B_DW-1:0]  b_dout,
    input logic [B_PPW-1:0] b_pout
);

    // R3
    a_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |=> (a_dout == $past(a_din)));

    // R3
    b_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_we) |=> (b_dout == $past(b_din)));

    // R4
    a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> ($stable(a_dout) && $stable(a_pout)));

    // R4
    b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> ($stable(b_dout) && $stable(b_pout)));

    // R9
    a_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((a_dout == '0) && (a_pout == '0)));

    // R9
    b_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((b_dout == '0) && (b_pout == '0)));

    if (par_bits(A_DW) > 0) begin : g_a_par
        // R7
        a_par_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> (a_pout == $past(a_pin)));
    end else begin : g_a_nopar
        // R8
        a_par_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            a_en |=> (a_pout == '0));
    end

    if (par_bits(B_DW) > 0) begin : g_b_par
        // R7
        b_par_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (b_en && b_we) |=> (b_pout == $past(b_pin)));
    end else begin : g_b_nopar
        // R8
        b_par_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            b_en |=> (b_pout == '0));
    end

endmodule

bind wm_dpram wm_dpram_chk #(.A_DW(A_DW), .B_DW(B_DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en   (a_en),
    .a_we   (a_we),
    .a_din  (a_din),
    .a_pin  (a_pin),
    .a_dout (a_dout),
    .a_pout (a_pout),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_din  (b_din),
    .b_pin  (b_pin),
    .b_dout (b_dout),
    .b_pout (b_pout)
);

// File: tb/sim_wm_dpram.sv
module sim_wm_dpram;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // Instance 0: x8 (+1 parity) against x32 (+4); instance 1: x1 against x16 (+2)
    localparam int DWS [2][2] = '{'{8, 32}, '{1, 16}};

    logic        en   [2][2];
    logic        we   [2][2];
    logic [13:0] addr [2][2];
    logic [31:0] din  [2][2];
    logic [3:0]  pin  [2][2];
    wire  [31:0] dout [2][2];
    wire  [3:0]  pout [2][2];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [16383:0] rd [2];
    logic [2047:0]  rp [2];

    wm_dpram #(.A_DW(8), .B_DW(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(en[0][0]), .a_we(we[0][0]), .a_addr(addr[0][0][10:0]),
        .a_din(din[0][0][7:0]), .a_pin(pin[0][0][0:0]),
        .a_dout(dout[0][0][7:0]), .a_pout(pout[0][0][0:0]),
        .b_en(en[0][1]), .b_we(we[0][1]), .b_addr(addr[0][1][8:0]),
        .b_din(din[0][1]), .b_pin(pin[0][1]),
        .b_dout(dout[0][1]), .b_pout(pout[0][1])
    );
    assign dout[0][0][31:8] = '0;
    assign pout[0][0][3:1]  = '0;

    wm_dpram #(.A_DW(1), .B_DW(16)) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_en(en[1][0]), .a_we(we[1][0]), .a_addr(addr[1][0][13:0]),
        .a_din(din[1][0][0:0]), .a_pin(pin[1][0][0:0]),
        .a_dout(dout[1][0][0:0]), .a_pout(pout[1][0][0:0]),
        .b_en(en[1][1]), .b_we(we[1][1]), .b_addr(addr[1][1][9:0]),
        .b_din(din[1][1][15:0]), .b_pin(pin[1][1][1:0]),
        .b_dout(dout[1][1][15:0]), .b_pout(pout[1][1][1:0])
    );
    assign dout[1][0][31:1]  = '0;
    assign pout[1][0][3:1]   = '0;
    assign dout[1][1][31:16] = '0;
    assign pout[1][1][3:2]   = '0;

    function automatic int pwid(input int dw);
        return (dw >= 8) ? dw / 8 : 0;
    endfunction

    function automatic logic [31:0] dmask(input int dw);
        return (dw == 32) ? 32'hFFFF_FFFF : ((32'd1 << dw) - 32'd1);
    endfunction

    task automatic ref_wr(input int i, input int p, input int a,
                          input logic [31:0] d, input logic [3:0] pp);
        int dw = DWS[i][p];
        int pw = pwid(dw);
        for (int k = 0; k < dw; k++) rd[i][a * dw + k] = d[k];
        for (int j = 0; j < pw; j++) rp[i][a * pw + j] = pp[j];
    endtask

    function automatic logic [31:0] exp_d(input int i, input int p, input int a);
        logic [31:0] v = '0;
        int dw = DWS[i][p];
        for (int k = 0; k < dw; k++) v[k] = rd[i][a * dw + k];
        return v;
    endfunction

    function automatic logic [3:0] exp_p(input int i, input int p, input int a);
        logic [3:0] v = '0;
        int pw = pwid(DWS[i][p]);
        for (int j = 0; j < pw; j++) v[j] = rp[i][a * pw + j];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access on one port; called and returning at a falling edge
    task automatic op(input int i, input int p, input bit w, input int a,
                      input logic [31:0] d, input logic [3:0] pp, input string req);
        logic [31:0] m = dmask(DWS[i][p]);
        en[i][p]   = 1'b1;
        we[i][p]   = w;
        addr[i][p] = 14'(a);
        din[i][p]  = d & m;
        pin[i][p]  = pp;
        @(posedge clk);
        if (w) ref_wr(i, p, a, d & m, pp);
        @(negedge clk);
        en[i][p] = 1'b0;
        we[i][p] = 1'b0;
        check({req, " data"}, dout[i][p], exp_d(i, p, a));
        check({req, " parity"}, {28'd0, pout[i][p]}, {28'd0, exp_p(i, p, a)});
    endtask

    typedef struct packed {
        logic [1:0]  inst;
        logic        port;
        logic        wr;
        logic [13:0] a;
        logic [31:0] d;
        logic [3:0]  pp;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        // instance 0: bytes packed into a word, word split into bytes
        '{2'd0, 1'b0, 1'b1, 14'd40,    32'h11,        4'b0001},
        '{2'd0, 1'b0, 1'b1, 14'd41,    32'h22,        4'b0000},
        '{2'd0, 1'b0, 1'b1, 14'd42,    32'h33,        4'b0001},
        '{2'd0, 1'b0, 1'b1, 14'd43,    32'h44,        4'b0000},
        '{2'd0, 1'b1, 1'b0, 14'd10,    32'h0,         4'b0000},
        '{2'd0, 1'b1, 1'b1, 14'd20,    32'hDEADBEEF,  4'b1010},
        '{2'd0, 1'b0, 1'b0, 14'd80,    32'h0,         4'b0000},
        '{2'd0, 1'b0, 1'b0, 14'd81,    32'h0,         4'b0000},
        '{2'd0, 1'b0, 1'b0, 14'd82,    32'h0,         4'b0000},
        '{2'd0, 1'b0, 1'b0, 14'd83,    32'h0,         4'b0000},
        '{2'd0, 1'b0, 1'b1, 14'd2047,  32'h5A,        4'b0001},
        '{2'd0, 1'b1, 1'b0, 14'd511,   32'h0,         4'b0000},
        // instance 1: bits packed into a halfword, halfword split into bits
        '{2'd1, 1'b0, 1'b1, 14'd80,    32'h1,         4'b0000},
        '{2'd1, 1'b0, 1'b1, 14'd81,    32'h0,         4'b0001},
        '{2'd1, 1'b0, 1'b1, 14'd95,    32'h1,         4'b0001},
        '{2'd1, 1'b1, 1'b0, 14'd5,     32'h0,         4'b0000},
        '{2'd1, 1'b1, 1'b1, 14'd7,     32'hA5C3,      4'b0010},
        '{2'd1, 1'b0, 1'b0, 14'd112,   32'h0,         4'b0000},
        '{2'd1, 1'b0, 1'b0, 14'd113,   32'h0,         4'b0000},
        '{2'd1, 1'b0, 1'b0, 14'd127,   32'h0,         4'b0000},
        '{2'd1, 1'b0, 1'b1, 14'd16383, 32'h1,         4'b0001},
        '{2'd1, 1'b1, 1'b0, 14'd1023,  32'h0,         4'b0000},
        '{2'd1, 1'b1, 1'b1, 14'd3,     32'h1234,      4'b0000},
        '{2'd1, 1'b0, 1'b1, 14'd48,    32'h1,         4'b0001}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_d;
        logic [3:0]  old_p;
        logic [31:0] held;
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 2; p++) begin
                en[i][p] = 1'b0; we[i][p] = 1'b0; addr[i][p] = '0;
                din[i][p] = '0;  pin[i][p] = '0;
            end
        end
        repeat (3) @(negedge clk);

        // R9: outputs cleared while reset is low
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 2; p++) begin
                check("R9 reset data", dout[i][p], 32'd0);
                check("R9 reset parity", {28'd0, pout[i][p]}, 32'd0);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R11 R1: fill every wide row through port B
        for (int i = 0; i < 2; i++) begin
            for (int a = 0; a < 16384 / DWS[i][1]; a++) begin
                op(i, 1, 1'b1, a, (32'(a) * 32'h9E3779B1) ^ {16'(i + 1), 16'h0},
                   4'(a * 7 + i), "R11 R3 fill");
            end
        end

        // R5 R6 R7 R8 R1: table of accesses
        foreach (VECS[v]) begin
            op(int'(VECS[v].inst), int'(VECS[v].port), VECS[v].wr, int'(VECS[v].a),
               VECS[v].d, VECS[v].pp, "R5 R6 R7 R8 table");
        end

        // R8: parity of halfword 3 untouched by x1 write with parity high
        op(1, 1, 1'b0, 3, 32'd0, 4'd0, "R8 parity kept");
        check("R8 parity value", {28'd0, pout[1][1]}, 32'd0);

        // R2: read result present one edge after the address
        op(0, 0, 1'b0, 41, 32'd0, 4'd0, "R2 latency");
        check("R2 byte 41", dout[0][0], 32'h22);

        // R4: enable low blocks a write and holds outputs
        op(0, 0, 1'b0, 5, 32'd0, 4'd0, "R4 pre-read");
        held = dout[0][0];
        we[0][0] = 1'b1; addr[0][0] = 14'd6; din[0][0] = ~exp_d(0, 0, 6) & 32'hFF;
        pin[0][0] = ~exp_p(0, 0, 6);
        @(posedge clk);
        @(negedge clk);
        we[0][0] = 1'b0;
        check("R4 hold", dout[0][0], held);
        op(0, 0, 1'b0, 6, 32'd0, 4'd0, "R4 no write");

        // R10: port A reads the byte port B overwrites on the same edge
        old_d = exp_d(0, 0, 80);
        old_p = exp_p(0, 0, 80);
        en[0][0] = 1'b1; we[0][0] = 1'b0; addr[0][0] = 14'd80;
        en[0][1] = 1'b1; we[0][1] = 1'b1; addr[0][1] = 14'd20;
        din[0][1] = 32'h0BADF00D; pin[0][1] = 4'b0110;
        @(posedge clk);
        ref_wr(0, 1, 20, 32'h0BADF00D, 4'b0110);
        @(negedge clk);
        en[0][0] = 1'b0; en[0][1] = 1'b0; we[0][1] = 1'b0;
        check("R10 old data", dout[0][0], old_d);
        check("R10 old parity", {28'd0, pout[0][0]}, {28'd0, old_p});
        check("R10 writer", dout[0][1], 32'h0BADF00D);
        op(0, 0, 1'b0, 80, 32'd0, 4'd0, "R10 new byte");
        check("R10 new byte value", dout[0][0], 32'h0D);

        // R9: reset mid-run clears outputs but keeps contents
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset", dout[0][1], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        op(0, 1, 1'b0, 10, 32'd0, 4'd0, "R9 contents kept");
        check("R9 word 10", dout[0][1], 32'h44332211);
        check("R7 word 10 parity", {28'd0, pout[0][1]}, 32'h5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule